// File: doc/BRIEF.md
# Oversampled SPI Bus Monitor

This block listens to an SPI bus without ever driving it. The bus pins arrive asynchronous to a much faster system clock. Each pin passes through a two-flop synchronizer. The serial clock is then compared, cycle by cycle, against its last stored level to find the data-capture edge for the selected clock mode.

On each capture edge the block shifts one bit from each data line into a word of configurable length, in either bit order. When a word is complete it is offered on a valid/ready output, tagged with the sample-counter values at its first and last captured bits. Every change of the chip-select line is reported as a one-cycle event carrying the old and new levels, and that change discards any partial word.

Present flags let either data line, or the chip select, be missing. When the chip select is missing, a single event marked "no chip select" is produced after reset.

Top module: `spi_bus_monitor`

## Requirements
- R1: The clock mode is {cfg_cpol, cfg_cpha}. Modes 0 and 3 capture on a rising synchronized SCLK edge, and modes 1 and 2 on a falling one. An edge is seen only when the synchronized SCLK differs from the stored previous level, and that stored level is 1 after reset. So in mode 1, an SCLK held low through reset yields one capture.
- R2: With cfg_lsb_first=0, the bit captured at index n (counting from 0) is placed at word position len-1-n, so the first bit is the MSB. With cfg_lsb_first=1 it is placed at position n.
- R3: The effective word length is cfg_word_len, limited to the range 1 to 32: a value of 0 acts as 1 and values above 32 act as 32. After len captured bits, the MOSI and MISO words are emitted together and assembly restarts from bit 0.
- R4: sample_cnt is 0 during reset and advances by one per system clock. word_t_start is the sample count in the cycle the first bit is captured, and word_t_end the count when the last bit is captured. Each equals the counter value two clocks after the SCLK pin change.
- R5: When cs_present=1, any change of the synchronized chip select produces a one-cycle cs_evt with cs_evt_old and cs_evt_new. The same change clears the bit count and the partial data, even mid-word.
- R6: If the chip select is inactive when the first bit of a word is captured, word_cs_warn is 1 for that word. cfg_cs_active_high=0 means active-low (0 is active) and 1 means active-high.
- R7: A channel marked absent (mosi_present=0 or miso_present=0) is reported with its valid bit 0 and its data 0. cfg_error is 1 exactly when both data channels are absent.
- R8: With cs_present=0, one cs_evt with cs_evt_none=1 follows reset. After that, chip-select changes produce no events, do not clear partial words, and never raise word_cs_warn.
- R9: word_valid stays 1, with all word fields unchanged, until word_ready is 1. A word completed while an earlier one is still waiting is discarded.
- R10: After reset, word_valid is 0, cs_evt is 0 and cfg_error is 0 when both data channels are present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (oversampling) clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cpol | input | 1 | Idle clock level, high bit of mode |
| cfg_cpha | input | 1 | Capture on trailing edge, low bit of mode |
| cfg_lsb_first | input | 1 | 1: first bit is word bit 0 |
| cfg_cs_active_high | input | 1 | 1: chip select active when high |
| cfg_word_len | input | 6 | Bits per word, clamped to 1..32 |
| mosi_present | input | 1 | MOSI line is connected |
| miso_present | input | 1 | MISO line is connected |
| cs_present | input | 1 | Chip-select line is connected |
| spi_sclk | input | 1 | Bus clock, asynchronous |
| spi_mosi | input | 1 | Controller-to-target data, asynchronous |
| spi_miso | input | 1 | Target-to-controller data, asynchronous |
| spi_cs | input | 1 | Chip select, asynchronous |
| word_valid | output | 1 | A completed word is offered |
| word_ready | input | 1 | Consumer accepts the word |
| word_mosi | output | 32 | Assembled MOSI word |
| word_mosi_vld | output | 1 | MOSI word is meaningful |
| word_miso | output | 32 | Assembled MISO word |
| word_miso_vld | output | 1 | MISO word is meaningful |
| word_cs_warn | output | 1 | Chip select was inactive at first bit |
| word_t_start | output | 32 | Sample count at first bit |
| word_t_end | output | 32 | Sample count at last bit |
| cs_evt | output | 1 | One-cycle chip-select event |
| cs_evt_old | output | 1 | Chip-select level before change |
| cs_evt_new | output | 1 | Chip-select level after change |
| cs_evt_none | output | 1 | Event means no chip select is connected |
| cfg_error | output | 1 | Both data lines are absent |

## Verification
A pin change reaches the edge and timestamp logic two clocks after it is driven, so each expected timestamp is the bench's own cycle count at the drive plus two. Completed words and chip-select events are registered once more and appear three clocks after the pin change. The bench therefore waits several clocks after the last bit or the chip-select change before reading its monitors. It drives inputs one time unit after a rising edge and samples outputs on the falling edge. cfg_error is combinational and is read one cycle after the presence flags change.

// File: rtl/spimon_pkg.sv
package spimon_pkg;

    localparam int MAX_W = 32;
    localparam int TS_W  = 32;
    localparam int LEN_W = $clog2(MAX_W + 1);
    localparam int IDX_W = $clog2(MAX_W);

    typedef struct packed {
        logic [MAX_W-1:0] mosi;
        logic [MAX_W-1:0] miso;
        logic             mosi_vld;
        logic             miso_vld;
        logic             warn;
        logic [TS_W-1:0]  t_start;
        logic [TS_W-1:0]  t_end;
    } word_t;

    // Limit a configured word length to 1..MAX_W.
    function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] raw);
        if (raw == '0)
            return LEN_W'(1);
        else if (raw > LEN_W'(MAX_W))
            return LEN_W'(MAX_W);
        else
            return raw;
    endfunction

    // Word position of the bit captured at index idx.
    function automatic logic [IDX_W-1:0] bit_pos(input logic [LEN_W-1:0] idx,
                                                 input logic [LEN_W-1:0] len,
                                                 input logic             lsb_first);
        if (lsb_first)
            return IDX_W'(idx);
        else
            return IDX_W'(len - LEN_W'(1) - idx);
    endfunction

endpackage

// File: rtl/spimon_sync.sv
module spimon_sync #(
    parameter int              WIDTH   = 4,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= RST_VAL;
        else     stg[0] <= din;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[s] <= RST_VAL;
            else     stg[s] <= stg[s-1];
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/spimon_edge.sv
module spimon_edge (
    input  logic clk,
    input  logic rst,
    input  logic sclk_s,
    input  logic cpol,
    input  logic cpha,
    output logic cap
);
    logic prev_lvl;
    logic rise, fall;

    always_ff @(posedge clk) begin
        if (rst) prev_lvl <= 1'b1;
        else     prev_lvl <= sclk_s;
    end

    assign rise = sclk_s & ~prev_lvl;
    assign fall = ~sclk_s & prev_lvl;
    // Modes 0 and 3 (cpol equal to cpha) capture on rising edges.
    assign cap  = (cpol ~^ cpha) ? rise : fall;

    AST_EDGE_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
        cap |-> (sclk_s != $past(sclk_s))); // R1
endmodule

// File: rtl/spimon_csmon.sv
module spimon_csmon (
    input  logic clk,
    input  logic rst,
    input  logic cs_present,
    input  logic cs_s,
    output logic clr,
    output logic evt,
    output logic evt_old,
    output logic evt_new,
    output logic evt_none
);
    logic cs_prev;
    logic none_done;

    assign clr = cs_present && (cs_s != cs_prev);

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_prev   <= 1'b1;
            none_done <= 1'b0;
            evt       <= 1'b0;
            evt_old   <= 1'b0;
            evt_new   <= 1'b0;
            evt_none  <= 1'b0;
        end else begin
            cs_prev  <= cs_s;
            evt      <= 1'b0;
            evt_none <= 1'b0;
            if (!cs_present) begin
                if (!none_done) begin
                    evt       <= 1'b1;
                    evt_none  <= 1'b1;
                    evt_old   <= 1'b0;
                    evt_new   <= 1'b0;
                    none_done <= 1'b1;
                end
            end else if (cs_s != cs_prev) begin
                evt     <= 1'b1;
                evt_old <= cs_prev;
                evt_new <= cs_s;
            end
        end
    end

    AST_EVT_LEVELS_DIFFER: assert property (@(posedge clk) disable iff (rst)
        (evt && !evt_none) |-> (evt_old != evt_new)); // R5
endmodule

// File: rtl/spimon_assembler.sv
module spimon_assembler
    import spimon_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cap,
    input  logic             clr,
    input  logic             mosi_b,
    input  logic             miso_b,
    input  logic             mosi_present,
    input  logic             miso_present,
    input  logic             cs_inactive,
    input  logic             lsb_first,
    input  logic [LEN_W-1:0] len_raw,
    input  logic [TS_W-1:0]  tstamp,
    input  logic             ready,
    output logic             valid,
    output word_t            word
);
    logic [LEN_W-1:0] cnt, cnt_eff, cnt_n, len;
    logic [MAX_W-1:0] mosi_sr, miso_sr, mosi_full, miso_full, mosi_n, miso_n;
    logic [TS_W-1:0]  ts_start, ts_start_n;
    logic             warn_q, warn_n;
    logic             done;
    logic [IDX_W-1:0] pos;

    assign len     = clamp_len(len_raw);
    assign cnt_eff = clr ? '0 : cnt;
    assign pos     = bit_pos(cnt_eff, len, lsb_first);

    always_comb begin
        mosi_full  = clr ? '0 : mosi_sr;
        miso_full  = clr ? '0 : miso_sr;
        ts_start_n = ts_start;
        warn_n     = warn_q;
        cnt_n      = cnt_eff;
        done       = 1'b0;
        if (cap) begin
            if (cnt_eff == '0) begin
                ts_start_n = tstamp;
                warn_n     = cs_inactive;
            end
            if (mosi_present) mosi_full[pos] = mosi_b;
            if (miso_present) miso_full[pos] = miso_b;
            if (cnt_eff == len - LEN_W'(1)) begin
                done  = 1'b1;
                cnt_n = '0;
            end else begin
                cnt_n = cnt_eff + LEN_W'(1);
            end
        end
        mosi_n = done ? '0 : mosi_full;
        miso_n = done ? '0 : miso_full;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            mosi_sr  <= '0;
            miso_sr  <= '0;
            ts_start <= '0;
            warn_q   <= 1'b0;
        end else begin
            cnt      <= cnt_n;
            mosi_sr  <= mosi_n;
            miso_sr  <= miso_n;
            ts_start <= ts_start_n;
            warn_q   <= warn_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            word  <= '0;
        end else if (done && (!valid || ready)) begin
            valid         <= 1'b1;
            word.mosi     <= mosi_present ? mosi_full : '0;
            word.miso     <= miso_present ? miso_full : '0;
            word.mosi_vld <= mosi_present;
            word.miso_vld <= miso_present;
            word.warn     <= warn_n;
            word.t_start  <= ts_start_n;
            word.t_end    <= tstamp;
        end else if (valid && ready) begin
            valid <= 1'b0;
        end
    end

    AST_COUNT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!cap && !clr) |=> (cnt == $past(cnt))); // R3
    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt < LEN_W'(MAX_W)); // R3
    AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (rst)
        (valid && !ready) |=> (valid && $stable(word))); // R9
    AST_ABSENT_MISO_ZERO: assert property (@(posedge clk) disable iff (rst)
        (valid && !word.miso_vld) |-> (word.miso == '0)); // R7
    AST_ABSENT_MOSI_ZERO: assert property (@(posedge clk) disable iff (rst)
        (valid && !word.mosi_vld) |-> (word.mosi == '0)); // R7
endmodule

// File: rtl/spi_bus_monitor.sv
module spi_bus_monitor
    import spimon_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_cpol,
    input  logic             cfg_cpha,
    input  logic             cfg_lsb_first,
    input  logic             cfg_cs_active_high,
    input  logic [LEN_W-1:0] cfg_word_len,
    input  logic             mosi_present,
    input  logic             miso_present,
    input  logic             cs_present,
    input  logic             spi_sclk,
    input  logic             spi_mosi,
    input  logic             spi_miso,
    input  logic             spi_cs,
    output logic             word_valid,
    input  logic             word_ready,
    output logic [MAX_W-1:0] word_mosi,
    output logic             word_mosi_vld,
    output logic [MAX_W-1:0] word_miso,
    output logic             word_miso_vld,
    output logic             word_cs_warn,
    output logic [TS_W-1:0]  word_t_start,
    output logic [TS_W-1:0]  word_t_end,
    output logic             cs_evt,
    output logic             cs_evt_old,
    output logic             cs_evt_new,
    output logic             cs_evt_none,
    output logic             cfg_error
);
    // Bit order of the synchronizer bundle: {cs, sclk, miso, mosi}.
    localparam logic [3:0] PIN_RST = 4'b1100;

    logic [3:0]      pins_s;
    logic            sclk_s, cs_s, mosi_s, miso_s;
    logic            cap, clr, cs_inactive;
    logic [TS_W-1:0] sample_cnt;
    word_t           word;

    spimon_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) i_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({spi_cs, spi_sclk, spi_miso, spi_mosi}),
        .dout (pins_s)
    );

    assign {cs_s, sclk_s, miso_s, mosi_s} = pins_s;

    always_ff @(posedge clk) begin
        if (rst) sample_cnt <= '0;
        else     sample_cnt <= sample_cnt + TS_W'(1);
    end

    spimon_edge i_edge (
        .clk    (clk),
        .rst    (rst),
        .sclk_s (sclk_s),
        .cpol   (cfg_cpol),
        .cpha   (cfg_cpha),
        .cap    (cap)
    );

    spimon_csmon i_csmon (
        .clk        (clk),
        .rst        (rst),
        .cs_present (cs_present),
        .cs_s       (cs_s),
        .clr        (clr),
        .evt        (cs_evt),
        .evt_old    (cs_evt_old),
        .evt_new    (cs_evt_new),
        .evt_none   (cs_evt_none)
    );

    assign cs_inactive = cs_present && (cfg_cs_active_high ? ~cs_s : cs_s);

    spimon_assembler i_asm (
        .clk          (clk),
        .rst          (rst),
        .cap          (cap),
        .clr          (clr),
        .mosi_b       (mosi_s),
        .miso_b       (miso_s),
        .mosi_present (mosi_present),
        .miso_present (miso_present),
        .cs_inactive  (cs_inactive),
        .lsb_first    (cfg_lsb_first),
        .len_raw      (cfg_word_len),
        .tstamp       (sample_cnt),
        .ready        (word_ready),
        .valid        (word_valid),
        .word         (word)
    );

    assign word_mosi     = word.mosi;
    assign word_miso     = word.miso;
    assign word_mosi_vld = word.mosi_vld;
    assign word_miso_vld = word.miso_vld;
    assign word_cs_warn  = word.warn;
    assign word_t_start  = word.t_start;
    assign word_t_end    = word.t_end;
    assign cfg_error     = !mosi_present && !miso_present;
endmodule

// File: tb/test_spi_bus_monitor.sv
module test_spi_bus_monitor;
    localparam int H = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_cpol = 0, cfg_cpha = 0, cfg_lsb_first = 0, cfg_cs_active_high = 0;
    logic [5:0] cfg_word_len = 6'd8;
    logic mosi_present = 1, miso_present = 1, cs_present = 1;
    logic spi_sclk = 0, spi_mosi = 0, spi_miso = 0, spi_cs = 1;
    logic word_ready = 1;
    logic word_valid, word_mosi_vld, word_miso_vld, word_cs_warn;
    logic [31:0] word_mosi, word_miso, word_t_start, word_t_end;
    logic cs_evt, cs_evt_old, cs_evt_new, cs_evt_none, cfg_error;

    always #2 clk = ~clk;

    spi_bus_monitor i_spi_bus_monitor (
        .clk(clk), .rst(rst), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .cfg_lsb_first(cfg_lsb_first), .cfg_cs_active_high(cfg_cs_active_high),
        .cfg_word_len(cfg_word_len), .mosi_present(mosi_present),
        .miso_present(miso_present), .cs_present(cs_present),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs(spi_cs),
        .word_valid(word_valid), .word_ready(word_ready), .word_mosi(word_mosi),
        .word_mosi_vld(word_mosi_vld), .word_miso(word_miso), .word_miso_vld(word_miso_vld),
        .word_cs_warn(word_cs_warn), .word_t_start(word_t_start), .word_t_end(word_t_end),
        .cs_evt(cs_evt), .cs_evt_old(cs_evt_old), .cs_evt_new(cs_evt_new),
        .cs_evt_none(cs_evt_none), .cfg_error(cfg_error)
    );

    // Bench cycle count: 0 in reset, +1 per clock.
    logic [31:0] bcnt;
    always @(posedge clk) begin
        if (rst) bcnt <= 0;
        else     bcnt <= bcnt + 1;
    end

    // Output monitors, sampled on the falling edge.
    int wcnt = 0, ecnt = 0;
    logic [31:0] l_mosi, l_miso, l_ts0, l_ts1;
    logic l_mv, l_sv, l_warn, e_old, e_new, e_none;
    always @(negedge clk) begin
        if (word_valid && word_ready) begin
            wcnt++;
            l_mosi = word_mosi; l_miso = word_miso; l_mv = word_mosi_vld;
            l_sv = word_miso_vld; l_warn = word_cs_warn;
            l_ts0 = word_t_start; l_ts1 = word_t_end;
        end
        if (cs_evt) begin
            ecnt++;
            e_old = cs_evt_old; e_new = cs_evt_new; e_none = cs_evt_none;
        end
    end

    int nchk = 0, nfail = 0;
    bit finished = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    logic [31:0] x_ts0, x_ts1;

    // Sends n bits of mv/sv in the configured order; records capture-edge timestamps.
    task automatic send(input logic [31:0] mv, input logic [31:0] sv, input int n);
        for (int i = 0; i < n; i++) begin
            int k;
            k = cfg_lsb_first ? i : n - 1 - i;
            spi_mosi = mv[k];
            spi_miso = sv[k];
            tick(H);
            spi_sclk = ~cfg_cpol;
            if (!cfg_cpha) begin
                if (i == 0) x_ts0 = bcnt + 2;
                if (i == n - 1) x_ts1 = bcnt + 2;
            end
            tick(H);
            spi_sclk = cfg_cpol;
            if (cfg_cpha) begin
                if (i == 0) x_ts0 = bcnt + 2;
                if (i == n - 1) x_ts1 = bcnt + 2;
            end
            tick(H);
        end
    endtask

    // Entry: {cpol, cpha, lsb_first, len[5:0], mosi[31:0], miso[31:0]}
    localparam logic [72:0] VEC [0:6] = '{
        {1'b0, 1'b0, 1'b0, 6'd8,  32'h000000A5, 32'h0000003C},
        {1'b0, 1'b1, 1'b0, 6'd8,  32'h0000005A, 32'h000000C3},
        {1'b1, 1'b0, 1'b1, 6'd8,  32'h0000001D, 32'h000000B2},
        {1'b1, 1'b1, 1'b1, 6'd16, 32'h00001234, 32'h0000ABCD},
        {1'b0, 1'b0, 1'b0, 6'd32, 32'hDEADBEEF, 32'h01234567},
        {1'b0, 1'b1, 1'b1, 6'd1,  32'h00000001, 32'h00000000},
        {1'b1, 1'b1, 1'b0, 6'd5,  32'h00000015, 32'h0000000A}
    };

    initial begin
        int wb, eb;
        tick(4);
        rst = 0;
        tick(3);
        // R10: reset state
        chk("R10 valid", {31'b0, word_valid}, 32'd0);
        chk("R10 events", ecnt, 0);
        chk("R10 cfg_error", {31'b0, cfg_error}, 32'd0);

        for (int v = 0; v < 7; v++) begin
            int n;
            {cfg_cpol, cfg_cpha, cfg_lsb_first, cfg_word_len} = VEC[v][72:64];
            n = int'(VEC[v][69:64]);
            spi_sclk = cfg_cpol; spi_mosi = 0; spi_miso = 0;
            tick(6);
            eb = ecnt;
            spi_cs = 0;
            tick(6);
            chk("R5 evt count", ecnt, eb + 1);
            chk("R5 evt levels", {30'b0, e_old, e_new}, 32'd2);
            wb = wcnt;
            send(VEC[v][63:32], VEC[v][31:0], n);
            tick(8);
            // R1 R2 R3 per mode/order/length
            chk("R1 word count", wcnt, wb + 1);
            chk("R2 mosi", l_mosi, VEC[v][63:32]);
            chk("R2 miso", l_miso, VEC[v][31:0]);
            chk("R6 warn clear", {31'b0, l_warn}, 32'd0);
            chk("R4 t_start", l_ts0, x_ts0);
            chk("R4 t_end", l_ts1, x_ts1);
            spi_cs = 1;
            tick(6);
        end

        // Directed: mode 0, MSB first, 8 bits
        cfg_cpol = 0; cfg_cpha = 0; cfg_lsb_first = 0; cfg_word_len = 8; spi_sclk = 0;
        tick(6);
        spi_cs = 0; tick(6);
        // R5: mid-word chip-select change discards the partial word
        wb = wcnt;
        send(32'h5, 32'h2, 3);
        spi_cs = 1; tick(6); spi_cs = 0; tick(6);
        send(32'h96, 32'h69, 8);
        tick(8);
        chk("R5 one word", wcnt, wb + 1);
        chk("R5 mosi after clear", l_mosi, 32'h96);
        chk("R5 miso after clear", l_miso, 32'h69);

        // R6: first bit with chip select inactive (active-low, cs=1)
        spi_cs = 1; tick(6);
        send(32'h3C, 32'h00, 8);
        tick(8);
        chk("R6 warn set", {31'b0, l_warn}, 32'd1);
        spi_cs = 0; tick(6);

        // R9: hold while not ready, later word discarded
        word_ready = 0;
        wb = wcnt;
        send(32'h11, 32'hEE, 8);
        tick(8);
        chk("R9 valid held", {31'b0, word_valid}, 32'd1);
        chk("R9 data held", word_mosi, 32'h11);
        send(32'h22, 32'hDD, 8);
        tick(8);
        chk("R9 data unchanged", word_mosi, 32'h11);
        word_ready = 1;
        tick(4);
        chk("R9 one accepted", wcnt, wb + 1);
        chk("R9 accepted data", l_mosi, 32'h11);
        chk("R9 valid drops", {31'b0, word_valid}, 32'd0);

        // R7: MISO absent
        miso_present = 0;
        send(32'h5A, 32'hFF, 8);
        tick(8);
        chk("R7 miso vld", {31'b0, l_sv}, 32'd0);
        chk("R7 miso data", l_miso, 32'd0);
        chk("R7 mosi vld", {31'b0, l_mv}, 32'd1);
        chk("R7 mosi data", l_mosi, 32'h5A);
        chk("R7 no error", {31'b0, cfg_error}, 32'd0);
        mosi_present = 0;
        tick(1);
        chk("R7 error both absent", {31'b0, cfg_error}, 32'd1);
        mosi_present = 1; miso_present = 1;
        tick(1);

        // R6: active-high polarity
        cfg_cs_active_high = 1;
        tick(2);
        send(32'h44, 32'h00, 8);
        tick(8);
        chk("R6 high pol inactive", {31'b0, l_warn}, 32'd1);
        spi_cs = 1; tick(6);
        send(32'h45, 32'h00, 8);
        tick(8);
        chk("R6 high pol active", {31'b0, l_warn}, 32'd0);
        cfg_cs_active_high = 0;
        spi_cs = 0; tick(6);

        // R3: length 0 behaves as 1
        cfg_word_len = 0;
        wb = wcnt;
        send(32'h1, 32'h0, 1);
        tick(8);
        chk("R3 len0 word", wcnt, wb + 1);
        chk("R3 len0 mosi", l_mosi, 32'h1);
        chk("R3 len0 ts", l_ts1, l_ts0);

        // R8 and R1: no chip select; mode 1, 1-bit words, SCLK low through reset
        cs_present = 0; cfg_cpol = 0; cfg_cpha = 1; cfg_word_len = 1; spi_sclk = 0;
        rst = 1;
        tick(4);
        wb = wcnt; eb = ecnt;
        rst = 0;
        tick(8);
        chk("R1 reset level capture", wcnt, wb + 1);
        chk("R8 none event", ecnt, eb + 1);
        chk("R8 none flag", {31'b0, e_none}, 32'd1);
        cfg_cpha = 0; cfg_word_len = 8;
        spi_cs = 1; tick(6); spi_cs = 0; tick(6); spi_cs = 1; tick(6);
        chk("R8 no later events", ecnt, eb + 1);
        wb = wcnt;
        send(32'hC, 32'h0, 4);
        spi_cs = 0; tick(6);
        send(32'h3, 32'h0, 4);
        tick(8);
        chk("R8 no clear", wcnt, wb + 1);
        chk("R8 word joined", l_mosi, 32'hC3);
        chk("R8 no warn", {31'b0, l_warn}, 32'd0);

        finished = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end
endmodule